// File: doc/BRIEF.md
# Zero-Run-Compressed VLC Codeword ROM

This block returns one variable-length codeword, up to 16 bits long, for a table address and shifts it out one bit per cycle, most significant bit first. Codewords in entropy-coding tables often begin with long runs of zeros. The block therefore keeps two read-only tables. The first holds only the low 6 bits of each codeword, right-aligned. The second holds the true length of each codeword in a 5-bit field. A controller reads both tables in the same cycle. When the length exceeds 6, it puts the missing zeros back in front of the stored bits, and then it serialises the result with a valid flag and a last flag.

Both tables are loaded at elaboration from parameter arrays. The default depth of 475 entries covers a typical baseline-profile codeword set. The logic that chooses a table address, and the logic that packs the bits into a stream, sit outside this block.

Top module: `vlc_zrom_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `bit_valid` and `bit_last` are 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `bit_valid` stays 0 in the cycle after that edge, and the first bit is presented after the second rising edge.
- R3: For a length L greater than 6, the block first emits L-6 zero bits and then the 6 stored bits, with stored bit 5 first.
- R4: For a length L from 1 to 6, the block emits only the low L bits of the stored field, with stored bit L-1 first.
- R5: The bits of one codeword appear in consecutive cycles. `bit_last` is 1 only together with the final bit of the codeword.
- R6: An entry whose length is 0, or whose length exceeds 16, emits no bits, and the block returns to `req_ready`=1.
- R7: While a codeword is being fetched or shifted, `req_ready` is 0 and any `req_valid` is ignored. No extra codeword follows.
- R8: An address at or above the table depth reads as length 0 and therefore emits no bits.
- R9: `req_ready` returns to 1 in the cycle after the last bit, so a new request can be accepted right away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe for a table lookup |
| req_addr | input | ADDR_W | Table entry to fetch |
| req_ready | output | 1 | High when idle and able to accept a request |
| bit_valid | output | 1 | A codeword bit is present on `bit_data` |
| bit_data | output | 1 | Serial codeword bit, most significant first |
| bit_last | output | 1 | Marks the final bit of the codeword |

## Verification
The bench builds the block with an 8-entry table and a 4-bit address. This leaves addresses 8 to 15 outside the table, so the out-of-range path can be reached. The table holds these entries:
- a 1-bit codeword;
- an 11-bit codeword whose single one sits at the end;
- a full 16-bit codeword;
- a 6-bit codeword and a 3-bit codeword, on either side of the zero-restoring threshold;
- a 7-bit codeword that needs exactly one restored zero;
- a length-0 entry;
- a length of 20, which exceeds the 16-bit maximum.

With these values, every branch of the realignment and both invalid-length cases can be reached from the ports.

// File: rtl/vlc_zrom_pkg.sv
package vlc_zrom_pkg;

   // Controller phases: waiting, table read in flight, shifting bits out
   typedef enum logic [1:0] {
      ZR_IDLE  = 2'd0,
      ZR_FETCH = 2'd1,
      ZR_SHIFT = 2'd2
   } zr_state_e;

   // Width of a counter able to hold values 0..n
   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/vlc_zrom_table.sv
// Registered-read table, contents fixed by a parameter array.
module vlc_zrom_table #(
   parameter int DATA_W = 6,
   parameter int DEPTH  = 475,
   parameter int ADDR_W = 9,
   parameter logic [DATA_W-1:0] CONTENT [DEPTH] = '{default: '0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int SPAN = 2 ** ADDR_W;

   logic [DATA_W-1:0] word_sel;

   generate
      if (DEPTH == SPAN) begin : g_full
         always_comb word_sel = CONTENT[rd_addr];
      end else begin : g_partial
         // addresses beyond the table read as all zeros
         always_comb begin
            if (int'(rd_addr) < DEPTH) word_sel = CONTENT[rd_addr];
            else                       word_sel = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data <= '0;
      else if (rd_en)  rd_data <= word_sel;
   end

endmodule

// File: rtl/vlc_zrom_ser.sv
// Controller: accepts a request, waits one read cycle, restores the
// stripped zero run and shifts the codeword out MSB first.
module vlc_zrom_ser
   import vlc_zrom_pkg::*;
#(
   parameter int STORE_W = 6,
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   output logic               rd_en,
   input  logic [STORE_W-1:0] rom_code,
   input  logic [LEN_W-1:0]   rom_len,
   output logic               bit_valid,
   output logic               bit_data,
   output logic               bit_last
);

   localparam int SIG_W = cnt_width(STORE_W);

   zr_state_e          st_q;
   logic [LEN_W-1:0]   pad_q;
   logic [SIG_W-1:0]   sig_q;
   logic [STORE_W-1:0] sreg_q;

   logic               ld_ok;
   logic [LEN_W-1:0]   ld_pad;
   logic [SIG_W-1:0]   ld_sig;
   logic [STORE_W-1:0] ld_sreg;
   int                 len_i;

   // Split the length into a zero-run part and a stored-bit part
   always_comb begin
      len_i   = int'(rom_len);
      ld_ok   = (len_i != 0) && (len_i <= MAX_LEN);
      if (len_i > STORE_W) begin
         ld_pad = LEN_W'(len_i - STORE_W);
         ld_sig = SIG_W'(STORE_W);
      end else begin
         ld_pad = '0;
         ld_sig = SIG_W'(len_i);
      end
      // left-align the used stored bits so the MSB sits at the top
      ld_sreg = rom_code << (STORE_W - int'(ld_sig));
   end

   assign req_ready = (st_q == ZR_IDLE);
   assign rd_en     = req_valid && req_ready;
   assign bit_valid = (st_q == ZR_SHIFT);
   assign bit_data  = bit_valid && (pad_q == '0) && sreg_q[STORE_W-1];
   assign bit_last  = bit_valid && (pad_q == '0) && (sig_q == SIG_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ZR_IDLE;
         pad_q  <= '0;
         sig_q  <= '0;
         sreg_q <= '0;
      end else begin
         unique case (st_q)
            ZR_IDLE: begin
               if (rd_en) st_q <= ZR_FETCH;
            end
            ZR_FETCH: begin
               pad_q  <= ld_pad;
               sig_q  <= ld_sig;
               sreg_q <= ld_sreg;
               st_q   <= ld_ok ? ZR_SHIFT : ZR_IDLE;
            end
            ZR_SHIFT: begin
               if (pad_q != '0) begin
                  pad_q <= pad_q - LEN_W'(1);
               end else begin
                  sreg_q <= sreg_q << 1;
                  sig_q  <= sig_q - SIG_W'(1);
                  if (sig_q == SIG_W'(1)) st_q <= ZR_IDLE;
               end
            end
            default: st_q <= ZR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vlc_zrom_top.sv
// Codeword lookup: compressed codeword table + length table + serialiser.
module vlc_zrom_top #(
   parameter int DEPTH   = 475,
   parameter int ADDR_W  = 9,
   parameter int STORE_W = 6,
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = 5,
   parameter logic [STORE_W-1:0] CODE_TABLE [DEPTH] = '{default: '0},
   parameter logic [LEN_W-1:0]   LEN_TABLE  [DEPTH] = '{default: '0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              bit_valid,
   output logic              bit_data,
   output logic              bit_last
);

   // Elaboration-time parameter checks
   generate
      if (STORE_W < 1) begin : g_bad_store
         $error("STORE_W must be at least 1");
      end
      if (MAX_LEN < STORE_W) begin : g_bad_max
         $error("MAX_LEN must not be below STORE_W");
      end
      if (LEN_W < $clog2(MAX_LEN + 1)) begin : g_bad_lenw
         $error("LEN_W too narrow for MAX_LEN");
      end
      if (DEPTH < 1 || DEPTH > 2 ** ADDR_W) begin : g_bad_depth
         $error("DEPTH must fit the address space");
      end
   endgenerate

   logic                rd_en;
   logic [STORE_W-1:0]  code_q;
   logic [LEN_W-1:0]    len_q;

   vlc_zrom_table #(
      .DATA_W (STORE_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .CONTENT(CODE_TABLE)
   ) i_code_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_addr(req_addr),
      .rd_data(code_q)
   );

   vlc_zrom_table #(
      .DATA_W (LEN_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .CONTENT(LEN_TABLE)
   ) i_len_tab (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_addr(req_addr),
      .rd_data(len_q)
   );

   vlc_zrom_ser #(
      .STORE_W(STORE_W),
      .MAX_LEN(MAX_LEN),
      .LEN_W  (LEN_W)
   ) i_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_ready(req_ready),
      .rd_en    (rd_en),
      .rom_code (code_q),
      .rom_len  (len_q),
      .bit_valid(bit_valid),
      .bit_data (bit_data),
      .bit_last (bit_last)
   );

endmodule

// File: rtl/vlc_zrom_chk.sv
module vlc_zrom_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic bit_valid,
   input logic bit_last
);

   // R5
   last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_last |-> bit_valid);

   // R5
   contiguous_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !bit_last) |=> bit_valid);

   // R7
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> !req_ready);

   // R2
   read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!bit_valid && !req_ready));

   // R2
   start_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_valid) |-> $past(req_valid && req_ready, 2));

   // R9
   ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_last |=> (req_ready && !bit_valid));

endmodule

bind vlc_zrom_top vlc_zrom_chk i_vlc_zrom_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .bit_valid(bit_valid),
   .bit_last (bit_last)
);

// File: tb/test_vlc_zrom_top.sv
`timescale 1ns/1ps
module test_vlc_zrom_top;

   localparam int DEPTH  = 8;
   localparam int ADDR_W = 4;
   localparam int SW     = 6;
   localparam int LW     = 5;
   localparam int MAXL   = 16;

   localparam logic [SW-1:0] TB_CODE [DEPTH] = '{
      6'b000001, 6'b000001, 6'b101101, 6'b110010,
      6'b000101, 6'b101010, 6'b111111, 6'b111111 };
   localparam logic [LW-1:0] TB_LEN [DEPTH] = '{
      5'd1, 5'd11, 5'd16, 5'd6, 5'd3, 5'd0, 5'd7, 5'd20 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic req_ready, bit_valid, bit_data, bit_last;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   vlc_zrom_top #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .STORE_W(SW), .MAX_LEN(MAXL), .LEN_W(LW),
      .CODE_TABLE(TB_CODE), .LEN_TABLE(TB_LEN)
   ) i_vlc_zrom_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .bit_valid(bit_valid), .bit_data(bit_data),
      .bit_last(bit_last)
   );

   task automatic check(input bit ok, input string rq,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Issue one request and collect the serial reply
   task automatic do_req(input logic [ADDR_W-1:0] a, output bit gap0, output bit v0,
                         output logic [31:0] got, output int n, output bit last_seen);
      got = '0; n = 0; last_seen = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      gap0 = !bit_valid && !req_ready;
      v0 = 1'b0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (i == 0) v0 = bit_valid;
         if (bit_valid) begin
            got = {got[30:0], bit_data};
            n++;
            if (bit_last) begin
               last_seen = 1'b1;
               break;
            end
         end else if (n > 0) begin
            break;
         end
      end
   endtask

   task automatic expect_code(input logic [ADDR_W-1:0] a, input string rq);
      bit gap0, v0, ls;
      logic [31:0] got, exp;
      int n, len;
      bit ok_len;
      len = (int'(a) < DEPTH) ? int'(TB_LEN[a]) : 0;
      ok_len = (len != 0) && (len <= MAXL);
      exp = 32'(TB_CODE[(int'(a) < DEPTH) ? a : '0]);
      if (ok_len) exp = exp & ((32'd1 << len) - 32'd1);
      else        exp = '0;
      do_req(a, gap0, v0, got, n, ls);
      check(gap0, {rq, " R2 idle read cycle"}, 32'(gap0), 32'd1);
      check(v0 == ok_len, {rq, " R2 first-bit timing"}, 32'(v0), 32'(ok_len));
      check(n == (ok_len ? len : 0), {rq, " bit count"}, 32'(n), 32'(ok_len ? len : 0));
      check(got == exp, {rq, " codeword"}, got, exp);
      check(ls == ok_len, {rq, " R5 last flag"}, 32'(ls), 32'(ok_len));
   endtask

   task automatic t_reset;
      check(req_ready === 1'b1, "R1 ready at reset", 32'(req_ready), 32'd1);
      check(bit_valid === 1'b0 && bit_last === 1'b0, "R1 outputs idle at reset",
            32'({bit_valid, bit_last}), 32'd0);
   endtask

   task automatic t_long;
      expect_code(4'd1, "R3 eleven-bit");
      expect_code(4'd2, "R3 sixteen-bit");
      expect_code(4'd6, "R3 seven-bit");
   endtask

   task automatic t_short;
      expect_code(4'd0, "R4 one-bit");
      expect_code(4'd3, "R4 six-bit");
      expect_code(4'd4, "R4 three-bit");
   endtask

   task automatic t_invalid;
      expect_code(4'd5, "R6 zero length");
      expect_code(4'd7, "R6 oversize length");
      check(req_ready, "R6 ready after invalid", 32'(req_ready), 32'd1);
   endtask

   task automatic t_range;
      expect_code(4'd9, "R8 beyond depth");
      expect_code(4'd15, "R8 top address");
   endtask

   task automatic t_busy;
      bit busy_ok = 1'b1;
      bit extra = 1'b0;
      int n = 0;
      logic [31:0] got = '0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 4'd2;
      @(negedge clk);
      req_addr = 4'd0;               // keep strobing a different entry
      for (int i = 0; i < 4; i++) begin
         if (req_ready) busy_ok = 1'b0;
         if (bit_valid) begin got = {got[30:0], bit_data}; n++; end
         @(negedge clk);
      end
      req_valid = 1'b0;
      for (int i = 0; i < 24; i++) begin
         if (bit_valid) begin got = {got[30:0], bit_data}; n++; end
         if (bit_valid && bit_last) break;
         @(negedge clk);
      end
      check(busy_ok, "R7 ready low while busy", 32'(busy_ok), 32'd1);
      check(n == 16 && got == 32'h002D, "R7 stream unaffected", got, 32'h002D);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (bit_valid) extra = 1'b1;
      end
      check(!extra, "R7 ignored request leaves no codeword", 32'(extra), 32'd0);
   endtask

   task automatic t_b2b;
      expect_code(4'd4, "R9 first");
      @(negedge clk);
      check(req_ready, "R9 ready right after last", 32'(req_ready), 32'd1);
      expect_code(4'd6, "R9 second");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_long();
      t_short();
      t_invalid();
      t_range();
      t_busy();
      t_b2b();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule